// File: doc/BRIEF.md
# Random Generator Control Front End

This block is the register-mapped control and status face of a hardware random-number source. Software sees a 32-bit word interface with five registers: control, status, data, noise-source setup and health-test setup. A 32-bit linear feedback shift register stands in for the physical entropy source. The block produces a new word only while generation is enabled, no conditional reset is in progress and no seed error is present. It reports each word through a data-ready flag.

Configuration has a strict loading rule. The configuration fields of the control register change only in a write that also raises conditional reset. Lowering conditional reset starts a fixed restart period, during which the bit still reads as 1. A seed-error input pin and a clock-error input pin model faults. A seed error halts output and raises a current flag and a sticky flag. The current flag clears by itself once the fault is gone, or at the end of a conditional reset. The sticky flag stays until software clears it. A lock bit freezes the configuration until the next reset.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, the control, status, noise-setup and health-setup registers all read 0, and a data read returns 0.
- R2: With the divider field at 0, data ready (status bit 0) rises READY_TICKS (4) clock cycles after a control write sets enable (bit 2). A data-register read returns a nonzero word and clears data ready, and the next word is ready 4 cycles later and differs from the last one.
- R3: The divider exponent in control bits 19:16 stretches each generation step to 2^exponent clock cycles. With exponent 2, data ready rises 16 cycles after generation becomes possible.
- R4: The configuration fields (control bits 25:8 and bit 5) are loaded only by a control write that also has bit 30 set; any other control write leaves them unchanged. Control reads back lock at bit 31, conditional reset at bit 30, bits 25:8 at 25:8, bit 5 at 5, enable at bit 2, and zeros elsewhere.
- R5: Control bit 30 reads 1 while it is held at 1. After a write that changes it from 1 to 0, it keeps reading 1 for CRST_CYC (4) cycles. No word is produced during that time, and generation starts again afterwards.
- R6: While the seed-fault pin is high, status bit 2 (current seed error) and bit 6 (sticky seed error) are set, data ready clears on the next cycle, and a data read returns 0.
- R7: Once the seed-fault pin is low and no conditional reset is active, status bit 2 clears on the next clock edge and bit 6 stays set.
- R8: While a conditional reset is held or in progress, status bit 2 stays set. It clears at the edge that ends the restart period, provided the fault is gone.
- R9: Writing 0 to status bit 5 or 6 clears that flag, and writing 1 leaves it as it is. Writes have no effect on status bits 0, 1 and 2.
- R10: With control bit 5 at 0, the clock-fault pin sets status bit 1 (current) and bit 5 (sticky). With bit 5 at 1, the pin sets neither.
- R11: The noise-setup register (offset 0x0C) keeps write bits 17:0 and reads 0 above them. The health-setup register (offset 0x10) keeps all 32 bits.
- R12: A control write with bit 31 set locks the block. After that, configuration fields, noise-setup writes and health-setup writes are ignored, while enable still responds. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a data read consumes the word) |
| addr | input | 5 | Byte address: 0x00 control, 0x04 status, 0x08 data, 0x0C noise setup, 0x10 health setup |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| seed_fault_in | input | 1 | Injects a seed error while high |
| clk_fault_in | input | 1 | Injects a clock error while high |

## Verification
The bench counts the exact cycle at which data ready rises, both after enable and after a conditional reset with a nonzero divider. An off-by-one in the prescaler, the fill counter or the restart counter therefore moves the edge, and the check fails. It injects a seed error in two ways: briefly, where auto-recovery must clear only the current flag, and during a held conditional reset, where a design that recovers too early clears bit 2 before the restart period ends. The bench checks that a configuration write without bit 30 has no effect, that writing 1 to a sticky flag does not clear it, and that a locked block ignores setup writes. Each of these would read back a changed value in a faulty design.

// File: rtl/rng_ctrl.sv
module rng_ctrl #(
  parameter int          READY_TICKS  = 4,
  parameter int          CRST_CYC     = 4,
  parameter bit          AUTO_RECOVER = 1'b1,
  parameter logic [31:0] SEED         = 32'h1ACEB00C,
  parameter logic [31:0] POLY         = 32'h80200003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        seed_fault_in,
  input  logic        clk_fault_in
);
  localparam int FW = $clog2(READY_TICKS) + 1;
  localparam int CW = $clog2(CRST_CYC) + 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2,
                         A_NOISE = 3'd3, A_HLTH = 3'd4;

  logic          en_q, ced_q, lock_q, crst_q, busy_q;
  logic          drdy_q, secs_q, cecs_q, seis_q, ceis_q;
  logic [17:0]   cfg_q, noise_q;
  logic [31:0]   hlth_q, data_q, lfsr_q;
  logic [15:0]   pre_q;
  logic [FW-1:0] fill_q;
  logic [CW-1:0] bcnt_q;

  wire [2:0]  widx      = addr[4:2];
  wire        unused_ab = ^addr[1:0];
  wire        wr_ctrl   = wr_en && widx == A_CTRL;
  wire        wr_stat   = wr_en && widx == A_STAT;
  wire        crst_rd   = crst_q | busy_q;
  wire        running   = en_q & ~crst_rd & ~secs_q;
  wire [3:0]  div       = cfg_q[11:8];
  wire [15:0] mask      = ~(16'hFFFF << div);
  wire        tick      = running && ((pre_q & mask) == mask);
  wire        crst_done = busy_q && (bcnt_q == CW'(CRST_CYC - 1));
  wire        pop       = rd_en && widx == A_DATA && drdy_q && !secs_q;
  wire [31:0] lfsr_nx   = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? POLY : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ced_q <= 1'b0; lock_q <= 1'b0; crst_q <= 1'b0;
      busy_q <= 1'b0; bcnt_q <= '0; cfg_q <= '0; noise_q <= '0; hlth_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[2];
        crst_q <= wdata[30];
        if (wdata[31]) lock_q <= 1'b1;
        if (wdata[30] && !lock_q) begin
          cfg_q <= wdata[25:8];
          ced_q <= wdata[5];
        end
      end
      if (wr_ctrl && crst_q && !wdata[30]) begin
        busy_q <= 1'b1;
        bcnt_q <= '0;
      end else if (busy_q) begin
        if (crst_done) busy_q <= 1'b0;
        else           bcnt_q <= bcnt_q + 1'b1;
      end
      if (wr_en && widx == A_NOISE && !lock_q) noise_q <= wdata[17:0];
      if (wr_en && widx == A_HLTH && !lock_q)  hlth_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= 1'b0; seis_q <= 1'b0; cecs_q <= 1'b0; ceis_q <= 1'b0;
    end else begin
      if (seed_fault_in) secs_q <= 1'b1;
      else if (crst_done || (AUTO_RECOVER && !crst_rd)) secs_q <= 1'b0;
      if (seed_fault_in) seis_q <= 1'b1;
      else if (wr_stat && !wdata[6]) seis_q <= 1'b0;
      cecs_q <= clk_fault_in & ~ced_q;
      if (clk_fault_in && !ced_q) ceis_q <= 1'b1;
      else if (wr_stat && !wdata[5]) ceis_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0; fill_q <= '0; drdy_q <= 1'b0; data_q <= '0; lfsr_q <= SEED;
    end else if (!running) begin
      pre_q <= '0; fill_q <= '0; drdy_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 16'd1;
      lfsr_q <= lfsr_nx;
      if (pop) begin
        drdy_q <= 1'b0;
        fill_q <= '0;
      end else if (tick && !drdy_q) begin
        if (fill_q == FW'(READY_TICKS - 1)) begin
          drdy_q <= 1'b1;
          data_q <= lfsr_q;
          fill_q <= '0;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (widx)
      A_CTRL:  rdata = {lock_q, crst_rd, 4'b0, cfg_q, 2'b0, ced_q, 2'b0, en_q, 2'b0};
      A_STAT:  rdata = {25'b0, seis_q, ceis_q, 2'b0, secs_q, cecs_q, drdy_q};
      A_DATA:  rdata = (drdy_q && !secs_q) ? data_q : 32'h0;
      A_NOISE: rdata = {14'b0, noise_q};
      A_HLTH:  rdata = hlth_q;
      default: rdata = {31'b0, unused_ab & 1'b0};
    endcase
  end

  a_r6_seed_stops: assert property (@(posedge clk) disable iff (!rst_n)
    secs_q |=> !drdy_q);
  a_r6_sticky_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secs_q) |-> seis_q);
  a_r12_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r4_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && wdata[30]) |=> $stable({cfg_q, ced_q}));
  a_r2_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_q) |-> $past(en_q));
endmodule

// File: tb/tb_rng_ctrl.sv
module tb_rng_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        seed_fault_in = 1'b0, clk_fault_in = 1'b0;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  localparam logic [4:0] CTRL = 5'h00, STAT = 5'h04, DATA = 5'h08, NOISE = 5'h0C, HLTH = 5'h10;

  localparam logic [71:0] VEC [7] = '{
    {8'h0C, 32'hFFFFFFFF, 32'h0003FFFF},
    {8'h0C, 32'h0002B5BB, 32'h0002B5BB},
    {8'h10, 32'h0000969D, 32'h0000969D},
    {8'h10, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {8'h00, 32'h00F00D20, 32'h00000000},
    {8'h00, 32'h40F00D20, 32'h40F00D20},
    {8'h00, 32'h00000000, 32'h40F00D20}
  };

  rng_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .seed_fault_in(seed_fault_in),
                .clk_fault_in(clk_fault_in));

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rchk(input string r, input logic [4:0] a, input logic [31:0] m,
                      input logic [31:0] e);
    logic [31:0] v;
    addr = a;
    #1 v = rdata;
    chk(r, v & m, e);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    addr = DATA; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1, w2;
    cyc(2);
    rchk("R1 ctrl reset", CTRL, 32'hFFFFFFFF, 32'h0);
    rchk("R1 status reset", STAT, 32'hFFFFFFFF, 32'h0);
    rchk("R1 data reset", DATA, 32'hFFFFFFFF, 32'h0);
    rchk("R1 noise reset", NOISE, 32'hFFFFFFFF, 32'h0);
    rchk("R1 health reset", HLTH, 32'hFFFFFFFF, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rchk("R4 R11 vector readback", VEC[i][68:64], 32'hFFFFFFFF, VEC[i][31:0]);
    end
    cyc(3);
    rchk("R5 crst still busy", CTRL, 32'hFFFFFFFF, 32'h40F00D20);
    cyc(1);
    rchk("R5 crst finished", CTRL, 32'hFFFFFFFF, 32'h00F00D20);

    wr(CTRL, 32'h40000000); wr(CTRL, 32'h0); cyc(4);
    wr(CTRL, 32'h00000004);
    cyc(3); rchk("R2 not ready early", STAT, 32'h1, 32'h0);
    cyc(1); rchk("R2 ready after 4", STAT, 32'h1, 32'h1);
    pop(w1);
    chk("R2 word nonzero", {31'b0, w1 != 32'h0}, 32'h1);
    rchk("R2 read clears ready", STAT, 32'h1, 32'h0);
    cyc(3); rchk("R2 next not early", STAT, 32'h1, 32'h0);
    cyc(1); rchk("R2 next ready", STAT, 32'h1, 32'h1);
    pop(w2);
    chk("R2 words differ", {31'b0, w1 != w2}, 32'h1);

    wr(CTRL, 32'h40020004);
    wr(CTRL, 32'h00000004);
    cyc(19); rchk("R3 div2 not early", STAT, 32'h1, 32'h0);
    cyc(1);  rchk("R3 div2 ready at 20", STAT, 32'h1, 32'h1);
    pop(w1);
    chk("R3 word nonzero", {31'b0, w1 != 32'h0}, 32'h1);

    wr(CTRL, 32'h40000004); wr(CTRL, 32'h00000004);
    cyc(8); rchk("R5 restart produces word", STAT, 32'h1, 32'h1);

    seed_fault_in = 1'b1;
    @(negedge clk);
    rchk("R6 seed flags", STAT, 32'hFF, 32'h45);
    rd_en = 1'b1;
    rchk("R6 data zero in error", DATA, 32'hFFFFFFFF, 32'h0);
    rd_en = 1'b0;
    @(negedge clk);
    rchk("R6 ready dropped", STAT, 32'hFF, 32'h44);
    seed_fault_in = 1'b0;
    @(negedge clk);
    rchk("R7 auto recovery", STAT, 32'hFF, 32'h40);

    wr(STAT, 32'hFFFFFFFF);
    rchk("R9 write 1 keeps sticky", STAT, 32'h40, 32'h40);
    cyc(4);
    rchk("R9 ready before clear", STAT, 32'h1, 32'h1);
    wr(STAT, 32'h0);
    rchk("R9 write 0 clears, ready kept", STAT, 32'h47, 32'h01);

    seed_fault_in = 1'b1;
    @(negedge clk);
    wr(CTRL, 32'h40000004);
    seed_fault_in = 1'b0;
    @(negedge clk);
    rchk("R8 held crst keeps error", STAT, 32'h4, 32'h4);
    wr(CTRL, 32'h00000004);
    cyc(3); rchk("R8 error during restart", STAT, 32'h4, 32'h4);
    cyc(1); rchk("R8 error cleared at end", STAT, 32'h44, 32'h40);
    wr(STAT, 32'h0);

    clk_fault_in = 1'b1;
    @(negedge clk);
    rchk("R10 clock error flags", STAT, 32'h22, 32'h22);
    clk_fault_in = 1'b0;
    @(negedge clk);
    rchk("R10 sticky stays", STAT, 32'h22, 32'h20);
    wr(STAT, 32'h40);
    rchk("R9 clock sticky cleared", STAT, 32'h20, 32'h0);
    wr(CTRL, 32'h40000024); wr(CTRL, 32'h00000024); cyc(4);
    clk_fault_in = 1'b1;
    @(negedge clk);
    rchk("R10 detection off", STAT, 32'h22, 32'h0);
    clk_fault_in = 1'b0;

    wr(CTRL, 32'h80000024);
    rchk("R12 lock set", CTRL, 32'hFFFFFFFF, 32'h80000024);
    wr(CTRL, 32'h40F00D04);
    rchk("R12 config ignored", CTRL, 32'hFFFFFFFF, 32'hC0000024);
    wr(NOISE, 32'h00001234);
    rchk("R12 noise ignored", NOISE, 32'hFFFFFFFF, 32'h0002B5BB);
    wr(HLTH, 32'h0);
    rchk("R12 health ignored", HLTH, 32'hFFFFFFFF, 32'hA5A5A5A5);
    wr(CTRL, 32'h0);
    rchk("R12 enable free, lock kept", CTRL, 32'h80000004, 32'h80000000);

    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    rchk("R12 reset clears lock", CTRL, 32'hFFFFFFFF, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule